// File: doc/BRIEF.md
# Interrupt Enable and Status Controller

This block collects eight single-cycle event pulses from a data-acquisition core and turns them into sticky status flags. Two of the eight events are produced inside the block. One compares the sequencer's instruction address against a programmable trigger. The other compares the conversion-FIFO fill count against a programmable threshold. The remaining six events arrive as input pulses.

Software reaches the block through a simple register bus with two registers. The 16-bit enable register is read/write. Its low byte gates each flag onto the external interrupt line, and its upper bits hold the trigger and threshold values. The 16-bit status register is read-only. Its low byte holds the sticky flags and its upper bits mirror the live sequencer address and FIFO count. Reading the status register clears the flags. The interrupt output is a single active-high line.

Top module: `irq_ctrl`

## Requirements
- R1: Flag positions are: bit 0 watchdog limit, bit 1 sequencer address match, bit 2 FIFO threshold, bit 3 single auto-zero done, bit 4 full calibration done, bit 5 pause reached, bit 6 low supply, bit 7 wake from standby. A flag sets in the cycle after its event, whatever the value of the enable bits.
- R2: A set flag stays set until a status read or a reset, and a write to the status address has no effect on it.
- R3: `irq` is high exactly when some bit i in 0..7 has both status flag i and enable bit i set.
- R4: When `bus_rd` is asserted with `bus_addr` = 4'hA, `bus_rdata` returns the current status, and every flag with no new event in that cycle reads 0 from the next cycle on.
- R5: An event that occurs in the same cycle as a status read leaves its flag set after the read.
- R6: The enable register sits at `bus_addr` 4'h9. It is written in full when `bus_wr` is high and read back unchanged. `bus_rdata` always shows the addressed register, and any address other than 4'h9 or 4'hA reads 0.
- R7: Event 1 fires on a cycle with `seq_fetch` high and `seq_addr` equal to the trigger held in enable bits 10:8.
- R8: When the trigger is 0, the first fetch of address 0 after reset or after a `seq_start` pulse does not raise event 1. This includes a fetch in the same cycle as the `seq_start` pulse. Every later fetch of address 0 does raise it.
- R9: Event 2 fires once, in the cycle where `fifo_cnt` differs from its previous-cycle value and equals the threshold in enable bits 15:11. It does not fire again while the count holds.
- R10: Status bits 10:8 show `seq_addr` and status bits 15:11 show `fifo_cnt`, both live.
- R11: After reset the enable register and all flags are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the status register clears its flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| wdog_evt | input | 1 | Watchdog limit event pulse |
| azero_evt | input | 1 | Single auto-zero done pulse |
| cal_evt | input | 1 | Full calibration done pulse |
| pause_evt | input | 1 | Pause instruction reached pulse |
| lowsup_evt | input | 1 | Low supply detected pulse |
| wake_evt | input | 1 | Return from standby pulse |
| seq_start | input | 1 | Sequencer start pulse |
| seq_fetch | input | 1 | Sequencer decodes the instruction at seq_addr |
| seq_addr | input | 3 | Current sequencer instruction address |
| fifo_cnt | input | 5 | Conversions currently stored in the FIFO |
| irq | output | 1 | Active-high interrupt request |

## Verification
Assertions check on every cycle that flags stay set between reads and that a status read clears every flag except those with a new event in the same cycle. They also check that the interrupt line stays low with all enables off, and that the FIFO event cannot fire while both the count and the threshold hold still.

Only the bench scenarios can show the correct bit position for each source and the zero-trigger suppression that follows a start. The same holds for the re-arming of the FIFO event after the count moves away and returns, and for the decoding of every bus address. The bench covers these with a reference model driven by random traffic and with directed sequences.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int AW = 4,
  parameter int SEQ_W = 3,
  parameter int CNT_W = 5,
  parameter logic [AW-1:0] ENA_ADDR = 4'h9,
  parameter logic [AW-1:0] STS_ADDR = 4'hA,
  localparam int DW = 8 + SEQ_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             wdog_evt,
  input  logic             azero_evt,
  input  logic             cal_evt,
  input  logic             pause_evt,
  input  logic             lowsup_evt,
  input  logic             wake_evt,
  input  logic             seq_start,
  input  logic             seq_fetch,
  input  logic [SEQ_W-1:0] seq_addr,
  input  logic [CNT_W-1:0] fifo_cnt,
  output logic             irq
);

  logic [DW-1:0]    en_q;
  logic [7:0]       sts_q;
  logic             zero_seen_q;
  logic [CNT_W-1:0] cnt_prev_q;

  wire [SEQ_W-1:0] trig = en_q[8 +: SEQ_W];
  wire [CNT_W-1:0] thr  = en_q[8+SEQ_W +: CNT_W];

  wire zero_fetch = seq_fetch && (seq_addr == '0);
  wire first_zero = seq_start || !zero_seen_q;
  wire addr_hit   = seq_fetch && (seq_addr == trig) && !((trig == '0) && first_zero);
  wire fifo_hit   = (fifo_cnt == thr) && (cnt_prev_q != thr);

  wire [7:0] evt = {wake_evt, lowsup_evt, pause_evt, cal_evt,
                    azero_evt, fifo_hit, addr_hit, wdog_evt};

  wire rd_clr = bus_rd && (bus_addr == STS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      sts_q       <= '0;
      zero_seen_q <= 1'b0;
      cnt_prev_q  <= '0;
    end else begin
      sts_q       <= (rd_clr ? 8'h00 : sts_q) | evt;
      cnt_prev_q  <= fifo_cnt;
      zero_seen_q <= seq_start ? zero_fetch : (zero_seen_q || zero_fetch);
      if (bus_wr && bus_addr == ENA_ADDR)
        en_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ENA_ADDR)      bus_rdata = en_q;
    else if (bus_addr == STS_ADDR) bus_rdata = {fifo_cnt, seq_addr, sts_q};
  end

  assign irq = |(sts_q & en_q[7:0]);

  // R2
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((sts_q & ~$past(evt)) == 8'h00));

  // R5
  read_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((sts_q & $past(evt)) == $past(evt)));

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[7:0] == 8'h00) |-> !irq);

  // R9
  fifo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(fifo_cnt) && $stable(en_q)) |-> !fifo_hit);

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        wdog_evt, azero_evt, cal_evt, pause_evt, lowsup_evt, wake_evt;
  logic        seq_start, seq_fetch;
  logic [2:0]  seq_addr;
  logic [4:0]  fifo_cnt;
  logic        irq;

  irq_ctrl u_irq_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_en;
  logic [7:0]  m_sts;
  logic        m_zs;
  logic [4:0]  m_prev;

  function automatic logic [7:0] m_evt();
    logic [7:0] e;
    e = {wake_evt, lowsup_evt, pause_evt, cal_evt, azero_evt, 1'b0, 1'b0, wdog_evt};
    e[1] = seq_fetch && seq_addr == m_en[10:8] &&
           !(m_en[10:8] == 3'd0 && (seq_start || !m_zs));
    e[2] = fifo_cnt == m_en[15:11] && m_prev != m_en[15:11];
    return e;
  endfunction

  function automatic logic [15:0] m_rdata();
    if (bus_addr == 4'h9) return m_en;
    if (bus_addr == 4'hA) return {fifo_cnt, seq_addr, m_sts};
    return 16'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_addr = 4'h0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    wdog_evt = 0; azero_evt = 0; cal_evt = 0; pause_evt = 0; lowsup_evt = 0; wake_evt = 0;
    seq_start = 0; seq_fetch = 0; seq_addr = 0;
  endtask

  // inputs already set at negedge; check, advance model over one edge
  task automatic step();
    logic [7:0] e;
    #1;
    chk(irq === |(m_sts & m_en[7:0]), "R3 irq", {15'd0, irq}, {15'd0, |(m_sts & m_en[7:0])});
    chk(bus_rdata === m_rdata(), bus_addr == 4'hA ? "R10 status read" : "R6 register read",
        bus_rdata, m_rdata());
    e = m_evt();
    @(posedge clk);
    m_sts  = ((bus_rd && bus_addr == 4'hA) ? 8'h00 : m_sts) | e;
    m_zs   = seq_start ? (seq_fetch && seq_addr == 0) : (m_zs || (seq_fetch && seq_addr == 0));
    m_prev = fifo_cnt;
    if (bus_wr && bus_addr == 4'h9) m_en = bus_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_en(input logic [15:0] v);
    bus_addr = 4'h9; bus_wr = 1; bus_wdata = v; step();
  endtask

  task automatic peek_sts(input string tag, input logic [7:0] exp);
    bus_addr = 4'hA; #1;
    chk(bus_rdata[7:0] === exp, tag, {8'd0, bus_rdata[7:0]}, {8'd0, exp});
  endtask

  task automatic rd_sts();
    bus_addr = 4'hA; bus_rd = 1; step();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int src[6] = '{0, 3, 4, 5, 6, 7};
    void'($urandom(32'h1234abcd));
    idle(); fifo_cnt = 0; rst_n = 0;
    m_en = 0; m_sts = 0; m_zs = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    bus_addr = 4'h9; #1;
    chk(bus_rdata === 16'h0, "R11 enable after reset", bus_rdata, 16'h0);
    peek_sts("R11 flags after reset", 8'h00);
    chk(irq === 1'b0, "R11 irq after reset", {15'd0, irq}, 16'h0);
    step();

    // R1 bit positions, enables off
    foreach (src[k]) begin
      case (src[k])
        0: wdog_evt = 1; 3: azero_evt = 1; 4: cal_evt = 1;
        5: pause_evt = 1; 6: lowsup_evt = 1; default: wake_evt = 1;
      endcase
      step();
      peek_sts("R1 flag position", 8'(1 << src[k]));
      chk(irq === 1'b0, "R1 flag set with enable off", {15'd0, irq}, 16'h0);
      rd_sts();
      peek_sts("R4 cleared after read", 8'h00);
    end

    // R2 write to status address ignored, flag held
    cal_evt = 1; step();
    bus_addr = 4'hA; bus_wr = 1; bus_wdata = 16'h0000; step();
    step();
    peek_sts("R2 flag held", 8'h10);
    wr_en(16'h0010);
    chk(irq === 1'b1, "R3 enabled flag drives irq", {15'd0, irq}, 16'h1);

    // R5 event coinciding with read
    bus_addr = 4'hA; bus_rd = 1; wdog_evt = 1; step();
    peek_sts("R5 event kept over read", 8'h01);
    rd_sts();

    // R8 trigger zero suppression
    wr_en(16'h0002);
    seq_start = 1; step();
    seq_fetch = 1; seq_addr = 0; step();
    peek_sts("R8 first fetch of 0 suppressed", 8'h00);
    seq_fetch = 1; seq_addr = 3; step();
    seq_fetch = 1; seq_addr = 0; step();
    peek_sts("R8 second fetch of 0 fires", 8'h02);
    chk(irq === 1'b1, "R8 irq from address event", {15'd0, irq}, 16'h1);
    rd_sts();
    seq_start = 1; seq_fetch = 1; seq_addr = 0; step();
    peek_sts("R8 fetch with start suppressed", 8'h00);

    // R7 nonzero trigger
    wr_en(16'h0500);
    seq_fetch = 1; seq_addr = 5; step();
    peek_sts("R7 address match", 8'h02);
    rd_sts();

    // R9 FIFO threshold once
    wr_en({5'd5, 3'd0, 8'h04});
    fifo_cnt = 4; step();
    fifo_cnt = 5; step();
    peek_sts("R9 threshold reached", 8'h04);
    rd_sts(); step(); step();
    peek_sts("R9 no refire while held", 8'h00);
    fifo_cnt = 6; step();
    fifo_cnt = 5; step();
    peek_sts("R9 refire after leaving", 8'h04);
    rd_sts();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bus_addr   = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) bus_addr = 4'h9 + 4'($urandom_range(0, 1));
      bus_wr     = ($urandom_range(0, 5) == 0);
      bus_rd     = ($urandom_range(0, 3) == 0);
      bus_wdata  = 16'($urandom);
      wdog_evt   = ($urandom_range(0, 9) == 0);
      azero_evt  = ($urandom_range(0, 9) == 0);
      cal_evt    = ($urandom_range(0, 9) == 0);
      pause_evt  = ($urandom_range(0, 9) == 0);
      lowsup_evt = ($urandom_range(0, 9) == 0);
      wake_evt   = ($urandom_range(0, 9) == 0);
      seq_start  = ($urandom_range(0, 31) == 0);
      seq_fetch  = ($urandom_range(0, 1) == 0);
      seq_addr   = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: fifo_cnt = fifo_cnt + 5'd1;
        1: fifo_cnt = fifo_cnt - 5'd1;
        2: fifo_cnt = 5'($urandom);
        default: ;
      endcase
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule